// File: doc/BRIEF.md
# PWM period and duty measurement unit

This block times an external pulse-width-modulated signal. Two capture channels watch the same filtered input pin with opposite edge polarities and share one free-running counter. The edge seen by the first channel also acts as a trigger that clears the counter. That edge therefore records the full period. The second channel records the time from that clear to the opposite edge, which is the high time of the waveform.

Each input pin passes through a digital glitch filter before edge detection. Configuration inputs set the pin each channel watches, the polarity of each channel, which channel edge drives the trigger, and whether the trigger clears the counter. A counting enable and a wrap limit are also configurable. Each channel has a capture flag and an overcapture flag. An update flag marks a counter wrap, which means the measurement overflowed. Each flag has its own clear strobe.

The inputs are taken to be synchronous to `clk`. A level change on a pin is stored in a capture register FILT_LEN+1 rising clock edges after the first edge that samples the new level.

Top module: `pwm_meas`

## Requirements
- R1: A pin's filtered level changes only after FILT_LEN consecutive clock samples at the new level (default 3). A pulse lasting FILT_LEN-1 clocks causes no capture on either channel.
- R2: Channel mapping codes. For channel 1, code 01 selects pin A and code 10 selects pin B. For channel 2, code 01 selects pin B and code 10 selects pin A. Codes 00 and 11 leave the channel idle.
- R3: A channel polarity bit of 0 makes the channel react to rising edges. A value of 1 makes it react to falling edges.
- R4: Trigger select 101 takes the channel 1 edge as the trigger, 110 takes the channel 2 edge, and any other code gives no trigger. Slave mode 100 clears the counter to 0 on a trigger. Any other slave mode lets the counter run freely.
- R5: Channel 1 stores the counter value plus one. In the default setup (channel 1 on pin A, rising, trigger 101, mode 100), this equals the number of clocks between consecutive rising edges.
- R6: Channel 2 stores the counter value plus one. In the default setup (channel 2 on pin A, falling), this equals the high time in clocks.
- R7: A channel stores a value only while its enable bit is 1. The counter clear from the trigger happens whatever the enable bits are.
- R8: A capture sets the channel's capture flag. A capture that arrives while the capture flag is already set also sets the overcapture flag.
- R9: A clear strobe clears its flag at the next clock edge. A set on the same edge takes priority over the clear.
- R10: When counting is enabled, a counter at the wrap limit goes to 0 and sets the update flag. A trigger clear on the same edge takes priority and does not set the flag.
- R11: After reset all captured values, flags and the counter are 0.
- R12: While the counting enable is 0 the counter holds its value, apart from trigger clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inA | input | 1 | Measured pin A |
| inB | input | 1 | Measured pin B |
| cntEn | input | 1 | Counting enable |
| autoReload | input | CNT_W | Counter wrap limit |
| ch1Sel | input | 2 | Channel 1 pin mapping |
| ch2Sel | input | 2 | Channel 2 pin mapping |
| ch1Pol | input | 1 | Channel 1 edge polarity |
| ch2Pol | input | 1 | Channel 2 edge polarity |
| ch1En | input | 1 | Channel 1 capture enable |
| ch2En | input | 1 | Channel 2 capture enable |
| trigSel | input | 3 | Trigger source select |
| slaveMode | input | 3 | Trigger action select |
| clrCap1 | input | 1 | Clear channel 1 capture flag |
| clrOvr1 | input | 1 | Clear channel 1 overcapture flag |
| clrCap2 | input | 1 | Clear channel 2 capture flag |
| clrOvr2 | input | 1 | Clear channel 2 overcapture flag |
| clrUpd | input | 1 | Clear update flag |
| periodVal | output | CNT_W | Channel 1 captured value |
| highVal | output | CNT_W | Channel 2 captured value |
| cap1Flag | output | 1 | Channel 1 capture flag |
| ovr1Flag | output | 1 | Channel 1 overcapture flag |
| cap2Flag | output | 1 | Channel 2 capture flag |
| ovr2Flag | output | 1 | Channel 2 overcapture flag |
| updFlag | output | 1 | Counter wrap flag |

## Verification
A fault in the counter or in its trigger clear makes the next captured period or high time wrong by a fixed offset. That shows at the ports one capture edge later, which is FILT_LEN+1 clocks after the pin change. A fault in the filter count or in the edge detector shifts both captures, or makes one go missing or appear twice. A pulse exactly one sample too short, or exactly long enough, exposes it through the capture flags. A fault in the flag logic shows one clock after a capture or a clear strobe. The flags are tested with captures that line up with clears, to check the set-over-clear priority.

// File: rtl/pwm_meas_pkg.sv
package pwm_meas_pkg;
  typedef struct packed {
    logic cap1;
    logic cap2;
    logic cntClr;
  } measStrobe_t;

  localparam logic [1:0] SEL_OWN   = 2'b01;
  localparam logic [1:0] SEL_CROSS = 2'b10;
  localparam logic [2:0] TRG_CH1   = 3'b101;
  localparam logic [2:0] TRG_CH2   = 3'b110;
  localparam logic [2:0] SMODE_RST = 3'b100;
endpackage

// File: rtl/pwm_meas_filter.sv
module pwm_meas_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic rise,
  output logic fall
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

  logic          lvl;
  logic          lvlPrev;
  logic [CW-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvl     <= 1'b0;
      lvlPrev <= 1'b0;
      runCnt  <= '0;
    end else begin
      lvlPrev <= lvl;
      if (pinIn != lvl) begin
        if (runCnt == LAST) begin
          lvl    <= pinIn;
          runCnt <= '0;
        end else begin
          runCnt <= runCnt + 1'b1;
        end
      end else begin
        runCnt <= '0;
      end
    end
  end

  assign rise = lvl & ~lvlPrev;
  assign fall = ~lvl & lvlPrev;

  // R1: a filtered level change always agrees with the sample just taken
  assert_filter_follows_pin_R1: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lvl) |-> ($past(pinIn) == lvl));
endmodule

// File: rtl/pwm_meas_ctrl.sv
module pwm_meas_ctrl
  import pwm_meas_pkg::*;
#(
  parameter int FILT_LEN = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inA,
  input  logic        inB,
  input  logic [1:0]  ch1Sel,
  input  logic [1:0]  ch2Sel,
  input  logic        ch1Pol,
  input  logic        ch2Pol,
  input  logic        ch1En,
  input  logic        ch2En,
  input  logic [2:0]  trigSel,
  input  logic [2:0]  slaveMode,
  output measStrobe_t strobe
);
  localparam int NPIN = 2;

  logic [NPIN-1:0] pins;
  logic [NPIN-1:0] riseP;
  logic [NPIN-1:0] fallP;
  logic            ev1;
  logic            ev2;
  logic            trig;

  assign pins = {inB, inA};

  for (genvar p = 0; p < NPIN; p++) begin : g_filt
    pwm_meas_filter #(.FILT_LEN(FILT_LEN)) i_filt (
      .clk  (clk),
      .rstN (rstN),
      .pinIn(pins[p]),
      .rise (riseP[p]),
      .fall (fallP[p])
    );
  end

  // channel 1: own pin is A; channel 2: own pin is B
  always_comb begin
    case (ch1Sel)
      SEL_OWN:   ev1 = ch1Pol ? fallP[0] : riseP[0];
      SEL_CROSS: ev1 = ch1Pol ? fallP[1] : riseP[1];
      default:   ev1 = 1'b0;
    endcase
    case (ch2Sel)
      SEL_OWN:   ev2 = ch2Pol ? fallP[1] : riseP[1];
      SEL_CROSS: ev2 = ch2Pol ? fallP[0] : riseP[0];
      default:   ev2 = 1'b0;
    endcase
    case (trigSel)
      TRG_CH1: trig = ev1;
      TRG_CH2: trig = ev2;
      default: trig = 1'b0;
    endcase
  end

  assign strobe.cap1   = ev1 & ch1En;
  assign strobe.cap2   = ev2 & ch2En;
  assign strobe.cntClr = trig & (slaveMode == SMODE_RST);

  // R2 / R3: both channels on pin A with opposite polarity never fire together
  assert_paired_edges_exclusive_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ch1Sel == SEL_OWN && ch2Sel == SEL_CROSS && ch1Pol != ch2Pol)
      |-> !(strobe.cap1 && strobe.cap2));
endmodule

// File: rtl/pwm_meas_dp.sv
module pwm_meas_dp
  import pwm_meas_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  measStrobe_t           strobe,
  input  logic                  cntEn,
  input  logic [CNT_W-1:0]      autoReload,
  input  logic [1:0]            clrCap,
  input  logic [1:0]            clrOvr,
  input  logic                  clrUpd,
  output logic [1:0][CNT_W-1:0] capVal,
  output logic [1:0]            capFlag,
  output logic [1:0]            ovrFlag,
  output logic                  updFlag
);
  localparam int NCH = 2;

  logic [CNT_W-1:0] counter;
  logic             wrapNow;
  logic [NCH-1:0]   capStb;

  assign capStb  = {strobe.cap2, strobe.cap1};
  assign wrapNow = cntEn && !strobe.cntClr && (counter == autoReload);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      counter <= '0;
      updFlag <= 1'b0;
    end else begin
      if (strobe.cntClr)  counter <= '0;
      else if (wrapNow)   counter <= '0;
      else if (cntEn)     counter <= counter + 1'b1;
      updFlag <= wrapNow | (updFlag & ~clrUpd);
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        capVal[c]  <= '0;
        capFlag[c] <= 1'b0;
        ovrFlag[c] <= 1'b0;
      end else begin
        // the clock of the edge itself is counted
        if (capStb[c]) capVal[c] <= counter + 1'b1;
        capFlag[c] <= capStb[c] | (capFlag[c] & ~clrCap[c]);
        ovrFlag[c] <= (capStb[c] & capFlag[c]) | (ovrFlag[c] & ~clrOvr[c]);
      end
    end

    // R8: overcapture only rises while a capture is pending
    assert_ovr_after_cap_R8: assert property (@(posedge clk) disable iff (!rstN)
      $rose(ovrFlag[c]) |-> $past(capFlag[c]));
    // R5 / R6: stored value is the counter seen at the capture edge plus one
    assert_capture_value_R5: assert property (@(posedge clk) disable iff (!rstN)
      capStb[c] |=> (capVal[c] == CNT_W'($past(counter) + 1'b1)));
  end

  // R4: a trigger clear leaves the counter at zero
  assert_trig_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntClr |=> (counter == '0));
  // R10: reaching the wrap limit wraps and flags
  assert_wrap_flag_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cntEn && !strobe.cntClr && counter == autoReload) |=> (counter == '0 && updFlag));
  // R12: counting enable low freezes the counter
  assert_hold_when_off_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!cntEn && !strobe.cntClr) |=> $stable(counter));
endmodule

// File: rtl/pwm_meas.sv
module pwm_meas
  import pwm_meas_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int FILT_LEN = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inA,
  input  logic             inB,
  input  logic             cntEn,
  input  logic [CNT_W-1:0] autoReload,
  input  logic [1:0]       ch1Sel,
  input  logic [1:0]       ch2Sel,
  input  logic             ch1Pol,
  input  logic             ch2Pol,
  input  logic             ch1En,
  input  logic             ch2En,
  input  logic [2:0]       trigSel,
  input  logic [2:0]       slaveMode,
  input  logic             clrCap1,
  input  logic             clrOvr1,
  input  logic             clrCap2,
  input  logic             clrOvr2,
  input  logic             clrUpd,
  output logic [CNT_W-1:0] periodVal,
  output logic [CNT_W-1:0] highVal,
  output logic             cap1Flag,
  output logic             ovr1Flag,
  output logic             cap2Flag,
  output logic             ovr2Flag,
  output logic             updFlag
);
  measStrobe_t            strobe;
  logic [1:0][CNT_W-1:0]  capVal;
  logic [1:0]             capFlag;
  logic [1:0]             ovrFlag;

  pwm_meas_ctrl #(.FILT_LEN(FILT_LEN)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inA      (inA),
    .inB      (inB),
    .ch1Sel   (ch1Sel),
    .ch2Sel   (ch2Sel),
    .ch1Pol   (ch1Pol),
    .ch2Pol   (ch2Pol),
    .ch1En    (ch1En),
    .ch2En    (ch2En),
    .trigSel  (trigSel),
    .slaveMode(slaveMode),
    .strobe   (strobe)
  );

  pwm_meas_dp #(.CNT_W(CNT_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cntEn     (cntEn),
    .autoReload(autoReload),
    .clrCap    ({clrCap2, clrCap1}),
    .clrOvr    ({clrOvr2, clrOvr1}),
    .clrUpd    (clrUpd),
    .capVal    (capVal),
    .capFlag   (capFlag),
    .ovrFlag   (ovrFlag),
    .updFlag   (updFlag)
  );

  assign periodVal = capVal[0];
  assign highVal   = capVal[1];
  assign cap1Flag  = capFlag[0];
  assign cap2Flag  = capFlag[1];
  assign ovr1Flag  = ovrFlag[0];
  assign ovr2Flag  = ovrFlag[1];
endmodule

// File: tb/test_pwm_meas.sv
module test_pwm_meas;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int F          = 3;
  localparam int SETTLE     = F + 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inA = 1'b0, inB = 1'b0, cntEn = 1'b0;
  logic [CNT_W-1:0] autoReload = '1;
  logic [1:0] ch1Sel = 2'b01, ch2Sel = 2'b10;
  logic ch1Pol = 1'b0, ch2Pol = 1'b1, ch1En = 1'b0, ch2En = 1'b0;
  logic [2:0] trigSel = 3'b101, slaveMode = 3'b100;
  logic clrCap1 = 1'b0, clrOvr1 = 1'b0, clrCap2 = 1'b0, clrOvr2 = 1'b0, clrUpd = 1'b0;
  logic [CNT_W-1:0] periodVal, highVal;
  logic cap1Flag, ovr1Flag, cap2Flag, ovr2Flag, updFlag;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_meas #(.CNT_W(CNT_W), .FILT_LEN(F)) i_pwm_meas (
    .clk(clk), .rstN(rstN), .inA(inA), .inB(inB), .cntEn(cntEn),
    .autoReload(autoReload), .ch1Sel(ch1Sel), .ch2Sel(ch2Sel),
    .ch1Pol(ch1Pol), .ch2Pol(ch2Pol), .ch1En(ch1En), .ch2En(ch2En),
    .trigSel(trigSel), .slaveMode(slaveMode),
    .clrCap1(clrCap1), .clrOvr1(clrOvr1), .clrCap2(clrCap2), .clrOvr2(clrOvr2),
    .clrUpd(clrUpd), .periodVal(periodVal), .highVal(highVal),
    .cap1Flag(cap1Flag), .ovr1Flag(ovr1Flag), .cap2Flag(cap2Flag),
    .ovr2Flag(ovr2Flag), .updFlag(updFlag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // P-clock periods with H clocks high, on pin A (usePinB=0) or pin B
  task automatic train(input int p, input int h, input int n, input bit usePinB);
    for (int k = 0; k < n; k++) begin
      if (usePinB) inB = 1'b1; else inA = 1'b1;
      repeat (h) @(negedge clk);
      if (usePinB) inB = 1'b0; else inA = 1'b0;
      repeat (p - h) @(negedge clk);
    end
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic clearAll();
    clrCap1 = 1'b1; clrOvr1 = 1'b1; clrCap2 = 1'b1; clrOvr2 = 1'b1; clrUpd = 1'b1;
    @(negedge clk);
    clrCap1 = 1'b0; clrOvr1 = 1'b0; clrCap2 = 1'b0; clrOvr2 = 1'b0; clrUpd = 1'b0;
    @(negedge clk);
  endtask

  task automatic defaults();
    ch1Sel = 2'b01; ch2Sel = 2'b10; ch1Pol = 1'b0; ch2Pol = 1'b1;
    ch1En = 1'b1; ch2En = 1'b1; trigSel = 3'b101; slaveMode = 3'b100;
    cntEn = 1'b1; autoReload = '1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [CNT_W-1:0] keep, p1, p2;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 periodVal", periodVal, 0);
    chk("R11 highVal", highVal, 0);
    chk("R11 flags", {cap1Flag, ovr1Flag, cap2Flag, ovr2Flag, updFlag}, 0);
    rstN = 1'b1;
    @(negedge clk);
    defaults();
    @(negedge clk);

    // R5 R6: sweep period and high time
    for (int p = 2*F; p <= 14; p++) begin
      for (int h = F; h <= p - F; h++) begin
        train(p, h, 3, 1'b0);
        chk($sformatf("R5 period p=%0d h=%0d", p, h), periodVal, p);
        chk($sformatf("R6 high p=%0d h=%0d", p, h), highVal, h);
      end
    end

    // R8: many captures left pending
    chk("R8 cap1 set", cap1Flag, 1);
    chk("R8 ovr1 set", ovr1Flag, 1);
    chk("R8 ovr2 set", ovr2Flag, 1);
    // R9: clears
    clearAll();
    chk("R9 flags cleared", {cap1Flag, ovr1Flag, cap2Flag, ovr2Flag}, 0);
    train(10, 4, 1, 1'b0);
    chk("R8 single capture flags", {cap1Flag, ovr1Flag, cap2Flag, ovr2Flag}, 4'b1010);
    train(10, 4, 1, 1'b0);
    chk("R8 second capture sets overcapture", {ovr1Flag, ovr2Flag}, 2'b11);

    // R9: set beats simultaneous clear
    clearAll();
    inA = 1'b1;
    repeat (F) @(negedge clk);
    clrCap1 = 1'b1;
    @(negedge clk);
    clrCap1 = 1'b0;
    chk("R9 set wins over clear", cap1Flag, 1);
    repeat (4) @(negedge clk);
    inA = 1'b0;
    repeat (SETTLE) @(negedge clk);

    // R1: glitch filter boundary
    clearAll();
    inA = 1'b1;
    repeat (F - 1) @(negedge clk);
    inA = 1'b0;
    repeat (SETTLE) @(negedge clk);
    chk("R1 short pulse ignored", {cap1Flag, cap2Flag}, 0);
    inA = 1'b1;
    repeat (F) @(negedge clk);
    inA = 1'b0;
    repeat (SETTLE) @(negedge clk);
    chk("R1 full-length pulse accepted", {cap1Flag, cap2Flag}, 2'b11);

    // R7: enables gate storage, not the trigger
    keep = periodVal;
    ch1En = 1'b0;
    train(9, 4, 3, 1'b0);
    chk("R7 ch1 disabled keeps period", periodVal, keep);
    chk("R7 trigger still clears", highVal, 4);
    ch1En = 1'b1; ch2En = 1'b0;
    train(11, 6, 3, 1'b0);
    chk("R7 ch2 disabled keeps high", highVal, 4);
    chk("R7 ch1 measures", periodVal, 11);
    ch2En = 1'b1;

    // R3: swapped polarities
    ch1Pol = 1'b1; ch2Pol = 1'b0;
    train(12, 5, 3, 1'b0);
    chk("R3 fall-to-fall period", periodVal, 12);
    chk("R3 low time on rising ch2", highVal, 7);
    ch1Pol = 1'b0; ch2Pol = 1'b1;

    // R2: mapping to pin B
    ch1Sel = 2'b10; ch2Sel = 2'b01;
    train(10, 3, 3, 1'b1);
    chk("R2 pin B period", periodVal, 10);
    chk("R2 pin B high", highVal, 3);
    clearAll();
    train(8, 4, 2, 1'b0);
    chk("R2 pin A unwatched", {cap1Flag, cap2Flag}, 0);
    ch1Sel = 2'b00; ch2Sel = 2'b11;
    train(8, 4, 2, 1'b0);
    train(8, 4, 2, 1'b1);
    chk("R2 idle codes", {cap1Flag, cap2Flag}, 0);
    ch1Sel = 2'b01; ch2Sel = 2'b10;

    // R4: trigger from channel 2
    trigSel = 3'b110;
    train(10, 4, 3, 1'b0);
    chk("R4 ch2 trigger period", periodVal, 6);
    chk("R4 ch2 trigger high", highVal, 10);
    // R4: no reset mode -> free running, difference of captures
    trigSel = 3'b101; slaveMode = 3'b000;
    train(10, 4, 1, 1'b0);
    p1 = periodVal;
    train(10, 4, 1, 1'b0);
    p2 = periodVal;
    chk("R4 free run spacing", 32'(CNT_W'(p2 - p1)), 10 + SETTLE);
    slaveMode = 3'b100; trigSel = 3'b000;
    train(10, 4, 1, 1'b0);
    p1 = periodVal;
    train(10, 4, 1, 1'b0);
    p2 = periodVal;
    chk("R4 no trigger spacing", 32'(CNT_W'(p2 - p1)), 10 + SETTLE);
    defaults();
    train(10, 4, 2, 1'b0);

    // R10: wrap flag
    autoReload = 50;
    clearAll();
    train(10, 4, 3, 1'b0);
    chk("R10 no wrap under limit", updFlag, 0);
    autoReload = 5;
    train(10, 4, 2, 1'b0);
    chk("R10 wrap sets flag", updFlag, 1);
    autoReload = '1;
    train(10, 4, 2, 1'b0);
    clearAll();
    chk("R9 update flag cleared", updFlag, 0);

    // R12: counting off
    cntEn = 1'b0;
    train(10, 4, 2, 1'b0);
    chk("R12 frozen period", periodVal, 1);
    chk("R12 frozen high", highVal, 1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule